// File: doc/BRIEF.md
# Flash Status Read Sequencer

This block fetches the one-byte status word of a parallel flash device once a program or erase operation has been issued. It pulls the device's active-low output enable down for a set number of clock cycles. It samples the eight data lines on the last of those cycles and keeps the byte in a register that the host can read. If the device still reports busy, the block releases the enable and reads again. It keeps doing this until the device reports ready, and then it signals completion with a one-cycle done pulse.

A read starts in one of two ways. The host can ask for one. The block also starts one by itself when the program-finished indication arrives while the automatic-read option is set. On the final ready read, the block checks the erase-fail and program-fail bits. Either one sets a sticky error flag. The host clears that flag by writing one to clear it. The interrupt output is the flag gated by an enable bit.

Top module: `flash_status_seq`

## Requirements
- R1: After reset, flash_oe_n_o is 1, status_o is 8'h00, and busy_o, done_o, err_flag_o and irq_o are all 0.
- R2: A start is taken when it is sampled while busy_o is 0. The start is host_req_i, or prog_done_i while auto_rd_en_i is 1. From the next cycle, flash_oe_n_o is 0 for exactly OE_CYCLES consecutive cycles (default 2). It then returns to 1 for at least REL_CYCLES cycles (default 1).
- R3: The byte on flash_io_i during the last low cycle of flash_oe_n_o is stored into status_o. status_o shows it from the first high cycle onward and changes at no other time.
- R4: A prog_done_i pulse while auto_rd_en_i is 0 is ignored: flash_oe_n_o stays 1 and busy_o stays 0.
- R5: A captured byte with bit 7 equal to 0 means busy. It produces no done pulse and does not change err_flag_o. A new low phase of flash_oe_n_o follows REL_CYCLES cycles after the release.
- R6: A captured byte with bit 7 equal to 1 means ready. done_o is then 1 for exactly one cycle, REL_CYCLES cycles after the release. In that same cycle busy_o returns to 0.
- R7: On the done cycle, err_flag_o becomes 1 if bit 5 (erase fail) or bit 4 (program fail) of the final byte is 1. Bits 6 and 3 to 0 have no effect on it.
- R8: err_flag_o stays 1 until a cycle with err_clr_i equal to 1, after which it is 0. If a new failure and a clear arrive in the same cycle, the flag ends up 1.
- R9: irq_o is 1 exactly when err_flag_o is 1 and irq_en_i is 1.
- R10: Start requests made while busy_o is 1 are ignored. They add no extra low phase of flash_oe_n_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host request for a status read |
| prog_done_i | input | 1 | Pulse marking the end of a program operation |
| auto_rd_en_i | input | 1 | Option bit: read status automatically after programming |
| irq_en_i | input | 1 | Interrupt enable for the error flag |
| err_clr_i | input | 1 | Write-one-to-clear strobe for the error flag |
| flash_io_i | input | 8 | Flash data lines |
| flash_oe_n_o | output | 1 | Flash output enable, active low |
| status_o | output | 8 | Last captured status byte |
| busy_o | output | 1 | A status read sequence is in progress |
| done_o | output | 1 | One-cycle pulse when a ready status has been captured |
| err_flag_o | output | 1 | Sticky status error flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions take for granted that flash_io_i matters only on the capture edge. They also assume that every start the block honours can be seen at its ports while busy_o is low. They do not limit how many busy reads may come in a row. The stimulus changes inputs only on falling clock edges and holds the data byte constant for each whole low phase. Every random sequence ends with a ready byte after at most two busy bytes, so each sequence ends with a done pulse. Extra requests and clear strobes are aimed at chosen cycles inside a sequence.

// File: rtl/fss_pkg.sv
package fss_pkg;
    localparam int unsigned BUS_W     = 8;
    localparam int unsigned RDY_BIT   = 7;
    localparam int unsigned EFAIL_BIT = 5;
    localparam int unsigned PFAIL_BIT = 4;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_STROBE  = 2'd1,
        PH_RELEASE = 2'd2
    } phase_e;

    function automatic logic stat_ready(input logic [BUS_W-1:0] b);
        return b[RDY_BIT];
    endfunction

    function automatic logic stat_fail(input logic [BUS_W-1:0] b);
        return b[EFAIL_BIT] | b[PFAIL_BIT];
    endfunction
endpackage

// File: rtl/fss_timer.sv
module fss_timer #(
    parameter int unsigned OE_CYCLES  = 2,
    parameter int unsigned REL_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic ready_i,
    output logic oe_n_o,
    output logic capture_o,
    output logic finish_o,
    output logic busy_o
);
    import fss_pkg::*;

    localparam int unsigned MAXC  = (OE_CYCLES > REL_CYCLES) ? OE_CYCLES : REL_CYCLES;
    localparam int unsigned CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);
    localparam logic [CNT_W-1:0] OE_LAST  = CNT_W'(OE_CYCLES - 1);
    localparam logic [CNT_W-1:0] REL_LAST = CNT_W'(REL_CYCLES - 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
    } tmr_s;

    tmr_s s_d, s_q;

    always_comb begin
        s_d       = s_q;
        capture_o = 1'b0;
        finish_o  = 1'b0;
        case (s_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.ph  = PH_STROBE;
                    s_d.cnt = '0;
                end
            end
            PH_STROBE: begin
                if (s_q.cnt == OE_LAST) begin
                    capture_o = 1'b1;
                    s_d.ph    = PH_RELEASE;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_RELEASE: begin
                if (s_q.cnt == REL_LAST) begin
                    s_d.cnt = '0;
                    if (ready_i) begin
                        s_d.ph   = PH_IDLE;
                        finish_o = 1'b1;
                    end else begin
                        s_d.ph = PH_STROBE;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d = '{ph: PH_IDLE, cnt: '0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_IDLE, cnt: '0};
        else        s_q <= s_d;
    end

    assign oe_n_o = (s_q.ph != PH_STROBE);
    assign busy_o = (s_q.ph != PH_IDLE);
endmodule

// File: rtl/fss_result.sv
module fss_result (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      capture_i,
    input  logic                      finish_i,
    input  logic [fss_pkg::BUS_W-1:0] bus_i,
    input  logic                      err_clr_i,
    input  logic                      irq_en_i,
    output logic [fss_pkg::BUS_W-1:0] stat_o,
    output logic                      done_o,
    output logic                      err_o,
    output logic                      irq_o
);
    import fss_pkg::*;

    typedef struct packed {
        logic [BUS_W-1:0] stat;
        logic             done;
        logic             err;
    } res_s;

    res_s r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = finish_i;
        if (capture_i) r_d.stat = bus_i;
        if (finish_i && stat_fail(r_q.stat)) r_d.err = 1'b1;
        else if (err_clr_i)                  r_d.err = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign stat_o = r_q.stat;
    assign done_o = r_q.done;
    assign err_o  = r_q.err;
    assign irq_o  = r_q.err & irq_en_i;
endmodule

// File: rtl/flash_status_seq.sv
module flash_status_seq #(
    parameter int unsigned OE_CYCLES  = 2,
    parameter int unsigned REL_CYCLES = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_req_i,
    input  logic       prog_done_i,
    input  logic       auto_rd_en_i,
    input  logic       irq_en_i,
    input  logic       err_clr_i,
    input  logic [7:0] flash_io_i,
    output logic       flash_oe_n_o,
    output logic [7:0] status_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_flag_o,
    output logic       irq_o
);
    import fss_pkg::*;

    logic start, capture, finish;

    assign start = !busy_o && (host_req_i || (auto_rd_en_i && prog_done_i));

    fss_timer #(
        .OE_CYCLES (OE_CYCLES),
        .REL_CYCLES(REL_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .ready_i  (stat_ready(status_o)),
        .oe_n_o   (flash_oe_n_o),
        .capture_o(capture),
        .finish_o (finish),
        .busy_o   (busy_o)
    );

    fss_result u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture_i(capture),
        .finish_i (finish),
        .bus_i    (flash_io_i),
        .err_clr_i(err_clr_i),
        .irq_en_i (irq_en_i),
        .stat_o   (status_o),
        .done_o   (done_o),
        .err_o    (err_flag_o),
        .irq_o    (irq_o)
    );
endmodule

// File: rtl/fss_checker.sv
module fss_checker #(
    parameter int unsigned OE_CYCLES = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       host_req_i,
    input logic       prog_done_i,
    input logic       auto_rd_en_i,
    input logic       irq_en_i,
    input logic       err_clr_i,
    input logic       flash_oe_n_o,
    input logic [7:0] status_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       err_flag_o,
    input logic       irq_o
);
    int unsigned low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            low_cnt <= 0;
        else if (!flash_oe_n_o) low_cnt <= low_cnt + 1;
        else                   low_cnt <= 0;
    end

    assert_start_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && (host_req_i || (auto_rd_en_i && prog_done_i))) |=> !flash_oe_n_o);

    assert_low_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_oe_n_o && low_cnt != 0) |-> (low_cnt == OE_CYCLES));

    assert_idle_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> flash_oe_n_o);

    assert_capture_time_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_o) |-> $rose(flash_oe_n_o));

    assert_done_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (status_o[7] && !busy_o));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_err_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag_o) |-> done_o);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag_o && !err_clr_i) |=> err_flag_o);

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (err_flag_o && irq_en_i));
endmodule

bind flash_status_seq fss_checker #(.OE_CYCLES(OE_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_req_i  (host_req_i),
    .prog_done_i (prog_done_i),
    .auto_rd_en_i(auto_rd_en_i),
    .irq_en_i    (irq_en_i),
    .err_clr_i   (err_clr_i),
    .flash_oe_n_o(flash_oe_n_o),
    .status_o    (status_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_flag_o  (err_flag_o),
    .irq_o       (irq_o)
);

// File: tb/sim_flash_status_seq.sv
module sim_flash_status_seq;
    localparam int CLK_PERIOD = 10;
    localparam int OE_CYC  = 2;
    localparam int REL_CYC = 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_req = 0, prog_done = 0, auto_en = 0, irq_en = 0, err_clr = 0;
    logic [7:0] io = 8'h00;
    logic oe_n, busy, done, err, irq;
    logic [7:0] stat;

    int n_chk = 0, n_bad = 0;
    logic exp_err = 0;
    logic [7:0] seq [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_status_seq #(.OE_CYCLES(OE_CYC), .REL_CYCLES(REL_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .host_req_i(host_req), .prog_done_i(prog_done),
        .auto_rd_en_i(auto_en), .irq_en_i(irq_en), .err_clr_i(err_clr),
        .flash_io_i(io), .flash_oe_n_o(oe_n), .status_o(stat), .busy_o(busy),
        .done_o(done), .err_flag_o(err), .irq_o(irq));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic fail_of(input logic [7:0] b);
        return b[5] | b[4];
    endfunction

    // one status read sequence of nb strobes; seq[nb-1] must be ready
    task automatic run_read(input bit use_auto, input int nb, input bit extra_req, input bit clr_last);
        int idx = 0, low = 0, since = 0;
        bit got = 0, clr_now = 0;
        @(negedge clk);
        if (use_auto) begin auto_en = 1; prog_done = 1; end
        else host_req = 1;
        @(negedge clk);
        prog_done = 0; host_req = 0;
        for (int c = 0; c < 200 && !got; c++) begin
            if (clr_now) begin err_clr = 0; clr_now = 0; end
            if (host_req) host_req = 0;
            if (!oe_n) begin
                if (low == 0 && idx > 0) chk("R5 restrobe gap", since, REL_CYC);
                io = seq[idx];
                low++;
                if (extra_req && idx == 0 && low == 1) host_req = 1;
            end else if (low > 0) begin
                chk("R2 low length", low, OE_CYC);
                chk("R3 captured byte", stat, seq[idx]);
                idx++; low = 0; since = 0;
                if (clr_last && idx == nb) begin err_clr = 1; clr_now = 1; end
            end
            if (done) begin
                got = 1;
                chk("R6 done timing", since, REL_CYC);
                chk("R10 strobe count", idx, nb);
                chk("R6 busy low on done", busy, 0);
                exp_err = fail_of(seq[nb-1]) ? 1'b1 : (clr_last ? 1'b0 : exp_err);
                chk("R7/R8 error flag", err, exp_err);
                chk("R9 irq", irq, exp_err & irq_en);
            end else if (oe_n && low == 0 && idx > 0 && idx < nb) begin
                chk("R5 no err change while busy reads", err, exp_err);
            end
            since++;
            @(negedge clk);
        end
        if (clr_now) err_clr = 0;
        chk("R6 done seen", got, 1);
        chk("R6 done one cycle", done, 0);
        auto_en = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk("R1 oe_n", oe_n, 1); chk("R1 status", stat, 0); chk("R1 busy", busy, 0);
        chk("R1 done", done, 0); chk("R1 err", err, 0); chk("R1 irq", irq, 0);
        rst_n = 1;
        @(negedge clk);

        // host read, ready and clean
        seq[0] = 8'h80; run_read(0, 1, 0, 0);
        // reserved bits set only: no error
        seq[0] = 8'hCF; run_read(0, 1, 0, 0);
        chk("R7 reserved bits ignored", err, 0);
        // auto read after programming, two busy reads carrying fail bits, then program fail
        irq_en = 0;
        seq[0] = 8'h30; seq[1] = 8'h70; seq[2] = 8'h90; run_read(1, 3, 0, 0);
        chk("R9 irq masked", irq, 0);
        @(negedge clk); irq_en = 1; @(negedge clk);
        chk("R9 irq enabled", irq, 1);
        // sticky across a clean read
        seq[0] = 8'h80; run_read(0, 1, 0, 0);
        chk("R8 sticky", err, 1);
        // clear strobe
        err_clr = 1; @(negedge clk); err_clr = 0;
        chk("R8 cleared", err, 0); exp_err = 0;
        // auto disabled: prog_done ignored
        auto_en = 0; prog_done = 1; @(negedge clk); prog_done = 0;
        for (int k = 0; k < 6; k++) begin
            chk("R4 oe stays high", oe_n, 1); chk("R4 not busy", busy, 0);
            @(negedge clk);
        end
        // request while busy ignored
        seq[0] = 8'h00; seq[1] = 8'hA0; run_read(0, 2, 1, 0);
        // clear and erase fail on the same cycle: set wins
        seq[0] = 8'hA0; run_read(0, 1, 0, 1);
        chk("R8 set beats clear", err, 1);
        seq[0] = 8'h80; run_read(0, 1, 0, 1);
        chk("R8 clear on clean done", err, 0);

        for (int it = 0; it < 40; it++) begin
            int nb = 1 + int'($urandom_range(2, 0));
            irq_en = 1'($urandom);
            for (int j = 0; j < nb; j++) begin
                seq[j] = 8'($urandom);
                seq[j][7] = (j == nb - 1);
            end
            run_read(1'($urandom), nb, 1'($urandom), ($urandom_range(3, 0) == 0));
            if ($urandom_range(3, 0) == 0) begin
                err_clr = 1; @(negedge clk); err_clr = 0; exp_err = 0;
                chk("R8 random clear", err, 0);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule